// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block is a synchronous power-on reset sequencer. It takes supply-good flags from external voltage comparators and drives the device reset and the controls for the user I/O. The monitored flags are the core, I/O and analog rails, an optional battery rail, and one flag for each I/O bank that carries configuration pins. Every flag is brought into the clock domain through a synchronizer and then a glitch filter. Until the block reaches user mode it holds the device in reset, keeps every user I/O tristated and enables the weak pull-ups.

Reset is released only when two conditions hold: every required rail is good, and a power-on delay has run out. A mode-select pin field picks a fast or a standard length for that delay. The configuration start is further gated on the flags of the configuration banks, and it is given as a one-cycle strobe. When the configuration engine reports completion, the block enters user mode and releases the I/O.

In user mode the block watches for brown-out. A sag on the core, analog or battery rail returns it to reset and reruns the whole sequence. A sag on the I/O rail or on a bank flag is tolerated.

Top module: `por_sequencer`

## Requirements
- R1: After reset the outputs are dev_rst=1, io_hiz=1, io_pullup=1 and cfg_start=0, and they stay that way while no supply flag is good.
- R2: dev_rst stays at 1 until the filtered core_ok, io_ok and analog_ok are all 1. If any of the three drops during the power-on delay, the sequence restarts from reset and the full delay is counted again.
- R3: The power-on delay lasts FAST_CYCLES clock cycles when (mode_sel & FAST_MASK) == FAST_MATCH, and STD_CYCLES otherwise. With the defaults, mode_sel[0]=1 selects fast. Counted from the clock edge that first samples the last rail flag, dev_rst falls on edge number SYNC_STAGES+FILT_CYCLES+N, counting that first edge as number 0.
- R4: Configuration does not start, and dev_rst stays at 1, until all NBANK bits of bank_ok are good after filtering. Once the delay has run out, a bank flag that rises later lets dev_rst fall on edge SYNC_STAGES+FILT_CYCLES.
- R5: cfg_start is a single-cycle pulse. It is high in exactly the cycle in which dev_rst first reads 0.
- R6: io_hiz and io_pullup are both 1 in every state before user mode, including while configuration runs. The first clock edge that samples cfg_done=1 during configuration enters user mode, and from that cycle io_hiz=0 and io_pullup=0.
- R7: During configuration or user mode, a filtered drop of core_ok, analog_ok or battery_ok (when battery monitoring is enabled) sets dev_rst, io_hiz and io_pullup back to 1. Restoring the rail reruns the full sequence, including the delay and a new cfg_start pulse.
- R8: In user mode, a drop of io_ok or of any bank_ok bit has no effect: dev_rst stays 0 and io_hiz stays 0.
- R9: A low pulse on a supply flag that lasts fewer than FILT_CYCLES cycles is ignored, and the block stays in user mode.
- R10: With HAS_BATT=1, dev_rst stays at 1 until battery_ok is good, even when all the other rails are good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer flops |
| core_ok | input | 1 | Core rail good flag (asynchronous) |
| io_ok | input | 1 | I/O rail good flag (asynchronous) |
| analog_ok | input | 1 | Analog rail good flag (asynchronous) |
| battery_ok | input | 1 | Battery rail good flag, used when HAS_BATT=1 |
| bank_ok | input | NBANK | Good flags of the configuration I/O banks |
| mode_sel | input | MODE_W | Mode pins that select the delay length |
| cfg_done | input | 1 | Configuration complete, synchronous to clk |
| dev_rst | output | 1 | Device reset, active high |
| io_hiz | output | 1 | Tristate enable for all user I/O |
| io_pullup | output | 1 | Weak pull-up enable for user I/O |
| cfg_start | output | 1 | One-cycle configuration start strobe |

## Verification
The bench builds the block with FILT_CYCLES=3, FAST_CYCLES=20, STD_CYCLES=60 and HAS_BATT=1, and leaves the other parameters at their defaults. Delays this short let both delay modes be timed to the exact edge, from the last rail edge to the fall of reset, within a few dozen cycles. The same settings make reruns after brown-out affordable and bring the battery gating into reach. A filter length of three makes it possible to tell a two-cycle glitch apart from a real three-cycle sag.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_WAIT   = 3'd1,
        ST_DELAY  = 3'd2,
        ST_CONFIG = 3'd3,
        ST_USER   = 3'd4
    } seq_state_t;

    typedef struct packed {
        seq_state_t st;
        logic       start;
    } seq_regs_t;

    // index of each rail inside the filtered flag vector
    localparam int unsigned IDX_CORE   = 0;
    localparam int unsigned IDX_IO     = 1;
    localparam int unsigned IDX_ANALOG = 2;
    localparam int unsigned IDX_BATT   = 3;
    localparam int unsigned NUM_RAILS  = 4;

endpackage

// File: rtl/supply_filter.sv
module supply_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic good_out
);
    localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   level;
    } filt_regs_t;

    filt_regs_t r_d, r_q;
    logic       synced;

    assign synced = r_q.sync[SYNC_STAGES-1];

    always_comb begin
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC_STAGES-2:0], raw_in};
        if (synced == r_q.level) begin
            r_d.cnt = '0;
        end else if (r_q.cnt == LAST) begin
            r_d.level = synced;
            r_d.cnt   = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign good_out = r_q.level;

endmodule

// File: rtl/por_timer.sv
module por_timer #(
    parameter int unsigned FAST_CYCLES = 6000,
    parameter int unsigned STD_CYCLES  = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic fast,
    input  logic run,
    output logic expired
);
    localparam int unsigned MAXC = (FAST_CYCLES > STD_CYCLES) ? FAST_CYCLES : STD_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FAST_INIT = CW'(FAST_CYCLES - 1);
    localparam logic [CW-1:0] STD_INIT  = CW'(STD_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = fast ? FAST_INIT : STD_INIT;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/por_fsm.sv
module por_fsm
    import por_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_good,
    input  logic io_good,
    input  logic analog_good,
    input  logic batt_good,
    input  logic banks_good,
    input  logic cfg_done,
    input  logic tmr_expired,
    output logic tmr_load,
    output logic tmr_run,
    output logic dev_rst,
    output logic io_hiz,
    output logic io_pullup,
    output logic cfg_start
);
    seq_regs_t r_d, r_q;
    logic      keep_ok;
    logic      all_ok;

    // rails whose loss forces a full restart; the I/O rail is not one of them
    assign keep_ok = core_good && analog_good && batt_good;
    assign all_ok  = keep_ok && io_good;

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        unique case (r_q.st)
            ST_RESET: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (all_ok) begin
                    r_d.st   = ST_DELAY;
                    tmr_load = 1'b1;
                end
            end
            ST_DELAY: begin
                if (!all_ok) begin
                    r_d.st = ST_RESET;
                end else begin
                    tmr_run = 1'b1;
                    if (tmr_expired && banks_good) begin
                        r_d.st    = ST_CONFIG;
                        r_d.start = 1'b1;
                    end
                end
            end
            ST_CONFIG: begin
                if (!keep_ok) begin
                    r_d.st = ST_RESET;
                end else if (cfg_done) begin
                    r_d.st = ST_USER;
                end
            end
            ST_USER: begin
                if (!keep_ok) begin
                    r_d.st = ST_RESET;
                end
            end
            default: begin
                r_d.st = ST_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_RESET, start: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dev_rst   = (r_q.st == ST_RESET) || (r_q.st == ST_WAIT) || (r_q.st == ST_DELAY);
    assign io_hiz    = (r_q.st != ST_USER);
    assign io_pullup = (r_q.st != ST_USER);
    assign cfg_start = r_q.start;

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer
    import por_seq_pkg::*;
#(
    parameter int unsigned NBANK       = 4,
    parameter int unsigned MODE_W      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_CYCLES = 4,
    parameter int unsigned FAST_CYCLES = 6000,
    parameter int unsigned STD_CYCLES  = 100000,
    parameter bit          HAS_BATT    = 1'b0,
    parameter logic [MODE_W-1:0] FAST_MASK  = MODE_W'(1),
    parameter logic [MODE_W-1:0] FAST_MATCH = MODE_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_ok,
    input  logic              io_ok,
    input  logic              analog_ok,
    input  logic              battery_ok,
    input  logic [NBANK-1:0]  bank_ok,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              cfg_done,
    output logic              dev_rst,
    output logic              io_hiz,
    output logic              io_pullup,
    output logic              cfg_start
);
    localparam int unsigned NFLAGS = NUM_RAILS + NBANK;

    logic [NFLAGS-1:0] raw_flags;
    logic [NFLAGS-1:0] good_flags;
    logic              core_good, io_good, analog_good, batt_good, banks_good;
    logic              fast_sel;
    logic              tmr_load, tmr_run, tmr_expired;

    assign raw_flags = {bank_ok, battery_ok, analog_ok, io_ok, core_ok};

    for (genvar i = 0; i < NFLAGS; i++) begin : g_filt
        supply_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
        ) i_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (raw_flags[i]),
            .good_out(good_flags[i])
        );
    end

    assign core_good   = good_flags[IDX_CORE];
    assign io_good     = good_flags[IDX_IO];
    assign analog_good = good_flags[IDX_ANALOG];
    assign banks_good  = &good_flags[NFLAGS-1:NUM_RAILS];

    if (HAS_BATT) begin : g_batt
        assign batt_good = good_flags[IDX_BATT];
    end else begin : g_nobatt
        assign batt_good = 1'b1 | good_flags[IDX_BATT];
    end

    assign fast_sel = ((mode_sel & FAST_MASK) == (FAST_MATCH & FAST_MASK));

    por_timer #(
        .FAST_CYCLES(FAST_CYCLES),
        .STD_CYCLES (STD_CYCLES)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .fast   (fast_sel),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    por_fsm i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_good  (core_good),
        .io_good    (io_good),
        .analog_good(analog_good),
        .batt_good  (batt_good),
        .banks_good (banks_good),
        .cfg_done   (cfg_done),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_run    (tmr_run),
        .dev_rst    (dev_rst),
        .io_hiz     (io_hiz),
        .io_pullup  (io_pullup),
        .cfg_start  (cfg_start)
    );

endmodule

// File: rtl/por_seq_chk.sv
module por_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic dev_rst,
    input logic io_hiz,
    input logic io_pullup,
    input logic cfg_start,
    input logic core_good,
    input logic io_good,
    input logic analog_good,
    input logic batt_good,
    input logic banks_good
);
    // R6
    hiz_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rst |-> io_hiz);

    // R6
    pullup_with_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_hiz |-> io_pullup);

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start);

    // R5
    start_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> (!dev_rst && $past(dev_rst)));

    // R4
    start_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |-> $past(banks_good));

    // R2
    release_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_rst) |-> $past(core_good && io_good && analog_good && batt_good));

    // R7
    brownout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_rst && !(core_good && analog_good && batt_good)) |=> dev_rst);

    // R8
    io_sag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_hiz && core_good && analog_good && batt_good) |=> !io_hiz);

endmodule

bind por_sequencer por_seq_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_rst    (dev_rst),
    .io_hiz     (io_hiz),
    .io_pullup  (io_pullup),
    .cfg_start  (cfg_start),
    .core_good  (core_good),
    .io_good    (io_good),
    .analog_good(analog_good),
    .batt_good  (batt_good),
    .banks_good (banks_good)
);

// File: tb/test_por_sequencer.sv
module test_por_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int NBANK  = 4;
    localparam int MODE_W = 4;
    localparam int SYNC   = 2;
    localparam int FILT   = 3;
    localparam int FASTC  = 20;
    localparam int STDC   = 60;
    localparam int T_FAST = SYNC + FILT + FASTC + 1;
    localparam int T_STD  = SYNC + FILT + STDC + 1;
    localparam int T_BANK = SYNC + FILT + 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              core_ok, io_ok, analog_ok, battery_ok;
    logic [NBANK-1:0]  bank_ok;
    logic [MODE_W-1:0] mode_sel;
    logic              cfg_done;
    logic              dev_rst, io_hiz, io_pullup, cfg_start;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_sequencer #(
        .NBANK(NBANK), .MODE_W(MODE_W), .SYNC_STAGES(SYNC), .FILT_CYCLES(FILT),
        .FAST_CYCLES(FASTC), .STD_CYCLES(STDC), .HAS_BATT(1'b1)
    ) i_por_sequencer (
        .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .io_ok(io_ok),
        .analog_ok(analog_ok), .battery_ok(battery_ok), .bank_ok(bank_ok),
        .mode_sel(mode_sel), .cfg_done(cfg_done), .dev_rst(dev_rst),
        .io_hiz(io_hiz), .io_pullup(io_pullup), .cfg_start(cfg_start)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        tests++;
        if (act != exp_v) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // number of rising edges, from the next one, up to the one after which dev_rst is low
    task automatic measure(output int n);
        n = 0;
        while (n < 500) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!dev_rst) break;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        core_ok = 0; io_ok = 0; analog_ok = 0; battery_ok = 0;
        bank_ok = '0; mode_sel = 4'b0001; cfg_done = 0;
        step(3);
        rst_n = 1'b1;
        step(4);
    endtask

    task automatic all_up();
        core_ok = 1; io_ok = 1; analog_ok = 1; battery_ok = 1; bank_ok = '1;
    endtask

    task automatic bring_up();
        int n;
        do_reset();
        all_up();
        measure(n);
        step(2);
        cfg_done = 1;
        step(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        core_ok = 0; io_ok = 0; analog_ok = 0; battery_ok = 0;
        bank_ok = '0; mode_sel = '0; cfg_done = 0;
        step(2);
        chk("R1 dev_rst in reset", dev_rst, 1);
        chk("R1 io_hiz in reset", io_hiz, 1);
        chk("R1 io_pullup in reset", io_pullup, 1);
        chk("R1 cfg_start in reset", cfg_start, 0);
        rst_n = 1'b1;
        step(50);
        chk("R1 dev_rst with no supply", dev_rst, 1);
        chk("R1 cfg_start with no supply", cfg_start, 0);
    endtask

    task automatic t_fast();
        int n;
        do_reset();
        mode_sel = 4'b0001;
        all_up();
        measure(n);
        chk("R3 fast delay edges", n, T_FAST);
        chk("R5 cfg_start on release", cfg_start, 1);
        chk("R6 io_hiz during config", io_hiz, 1);
        chk("R6 io_pullup during config", io_pullup, 1);
        step(1);
        chk("R5 cfg_start single cycle", cfg_start, 0);
        step(3);
        chk("R6 still config without done", io_hiz, 1);
        cfg_done = 1;
        step(1);
        chk("R6 io_hiz released in user", io_hiz, 0);
        chk("R6 io_pullup off in user", io_pullup, 0);
        chk("R6 dev_rst low in user", dev_rst, 0);
    endtask

    task automatic t_std();
        int n;
        do_reset();
        mode_sel = 4'b1110;
        all_up();
        measure(n);
        chk("R3 standard delay edges", n, T_STD);
        chk("R5 cfg_start after standard delay", cfg_start, 1);
    endtask

    task automatic t_missing_rail();
        int n;
        do_reset();
        all_up();
        analog_ok = 0;
        step(T_STD + 20);
        chk("R2 reset held without analog", dev_rst, 1);
        analog_ok = 1;
        measure(n);
        chk("R2 release after analog good", n, T_FAST);
    endtask

    task automatic t_battery();
        int n;
        do_reset();
        all_up();
        battery_ok = 0;
        step(T_STD + 20);
        chk("R10 reset held without battery", dev_rst, 1);
        battery_ok = 1;
        measure(n);
        chk("R10 release after battery good", n, T_FAST);
    endtask

    task automatic t_drop_in_delay();
        int n;
        do_reset();
        all_up();
        step(12);
        chk("R2 still in delay", dev_rst, 1);
        io_ok = 0;
        step(8);
        io_ok = 1;
        measure(n);
        chk("R2 full delay rerun after drop", n, T_FAST);
    endtask

    task automatic t_bank_gate();
        int n;
        do_reset();
        all_up();
        bank_ok[2] = 1'b0;
        step(T_FAST + 20);
        chk("R4 reset held with bank low", dev_rst, 1);
        chk("R4 no start with bank low", cfg_start, 0);
        bank_ok[2] = 1'b1;
        measure(n);
        chk("R4 release after bank good", n, T_BANK);
        chk("R4 start after bank good", cfg_start, 1);
    endtask

    task automatic t_io_sag();
        int bad = 0;
        bring_up();
        chk("R8 in user before sag", io_hiz, 0);
        io_ok = 0;
        bank_ok[0] = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (dev_rst || io_hiz) bad++;
        end
        chk("R8 cycles disturbed by I/O sag", bad, 0);
        io_ok = 1;
        bank_ok[0] = 1'b1;
        step(10);
        chk("R8 user after sag", io_hiz, 0);
    endtask

    task automatic t_glitch();
        int bad = 0;
        bring_up();
        core_ok = 0;
        step(FILT - 1);
        core_ok = 1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (dev_rst || io_hiz) bad++;
        end
        chk("R9 cycles disturbed by short glitch", bad, 0);
    endtask

    task automatic t_brownout(input bit use_analog);
        int n;
        bring_up();
        if (use_analog) analog_ok = 0; else core_ok = 0;
        cfg_done = 0;
        step(10);
        chk("R7 dev_rst after brown-out", dev_rst, 1);
        chk("R7 io_hiz after brown-out", io_hiz, 1);
        chk("R7 io_pullup after brown-out", io_pullup, 1);
        if (use_analog) analog_ok = 1; else core_ok = 1;
        measure(n);
        chk("R7 rerun delay after brown-out", n, T_FAST);
        chk("R7 new cfg_start after brown-out", cfg_start, 1);
        cfg_done = 1;
        step(1);
        chk("R7 user again after rerun", io_hiz, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_std();
        t_missing_rail();
        t_battery();
        t_drop_in_delay();
        t_bank_gate();
        t_io_sag();
        t_glitch();
        t_brownout(1'b0);
        t_brownout(1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule